// File: doc/BRIEF.md
# VLIW Microcode Sequencer

This block steps a vector co-processor through a program stored as 64-bit two-slot instruction words. Each word holds a lower operation in its first 32-bit half and an upper operation in its second half. The sequencer reads one word per cycle through a combinational microcode read port and hands the two opcode fields to the execution units as strobes. It also reads four control flags in the upper half that govern the flow of the program. The arithmetic of both slots is outside the block.

A host loads a start address and pulses `start`, and the unit runs until an end flag, or an enabled debug or trap flag, stops it. The lower slot reports a taken branch with its target in the same cycle the word executes. The sequencer applies the delay slot and queues a branch that arrives inside a delay slot. Enabled debug and trap flags set sticky status bits, which the host clears, and raise a one-cycle interrupt pulse.

Top module: `vseq_top`

## Requirements
- R1: The program counter is a byte address. A start pulse loads it from `startPc` with its three low bits forced to zero. Each executed word advances it by 8, wrapping within `ADDR_W` bits.
- R2: While running, `upStrobe` is high every cycle and `upOp` equals upper-half bits 5:0 (`memData[37:32]`). `loOp` equals lower-half bits 31:25 (`memData[31:25]`).
- R3: When upper-half bit 31 (`memData[63]`) is set, `loStrobe` stays low and any branch request is ignored. The lower half is loaded into `immReg` at the end of that cycle.
- R4: When upper-half bit 30 (`memData[62]`) is set, exactly one further word executes. The running bit, `status[0]`, then clears.
- R5: A branch taken with no branch outstanding executes one delay-slot word. The program counter then takes the target.
- R6: A branch taken while a branch is outstanding has its target queued. When the first branch resolves, two words at the first target execute, and then the queued target is taken.
- R7: Upper-half bit 28 (`memData[60]`) with `brkEn` high sets sticky `status[1]` and pulses `irq`. The unit stops after the flagged word. With `brkEn` low the flag has no effect.
- R8: Upper-half bit 27 (`memData[59]`) with `trapEn` high sets sticky `status[2]` and pulses `irq`. The unit stops after the flagged word. With `trapEn` low the flag has no effect.
- R9: `irq` is high for one cycle per flag event. `dbgClr` clears `status[1]` and `trapClr` clears `status[2]`.
- R10: While stopped, no strobes are issued and `memAddr` holds until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load start address and begin running |
| startPc | input | ADDR_W | Start byte address |
| memAddr | output | ADDR_W | Microcode fetch byte address (the PC) |
| memData | input | 64 | Fetched word: [31:0] lower, [63:32] upper |
| brTaken | input | 1 | Lower slot reports a taken branch |
| brTarget | input | ADDR_W | Branch target byte address |
| brkEn | input | 1 | Enable halting on the debug flag |
| trapEn | input | 1 | Enable halting on the trap flag |
| dbgClr | input | 1 | Host clear of the debug status bit |
| trapClr | input | 1 | Host clear of the trap status bit |
| upStrobe | output | 1 | Upper operation issue |
| upOp | output | 6 | Upper opcode |
| loStrobe | output | 1 | Lower operation issue |
| loOp | output | 7 | Lower opcode |
| immReg | output | 32 | Immediate register |
| status | output | 3 | {trap, debug, running} |
| irq | output | 1 | Interrupt pulse |

## Verification
A corrupted branch or end counter appears on `memAddr` within one or two cycles as a missing or extra address in the fetch trace, or as a run of the wrong length. The bench records the full address trace of each program and compares it with the sequence expected from the flags. Status and interrupt faults appear one cycle after the flagged word. A stopped unit that keeps fetching appears at once as a strobe while the running bit is low.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef struct packed {
    logic loadStart;
    logic incPc;
    logic takeBr;
    logic armTgt;
    logic savePend;
    logic promoteIn;
    logic promotePend;
    logic loadImm;
  } seqCtl_t;
endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    immFlag,
  input  logic    endFlag,
  input  logic    dbgFlag,
  input  logic    trapFlag,
  input  logic    brTaken,
  input  logic    brkEn,
  input  logic    trapEn,
  input  logic    dbgClr,
  input  logic    trapClr,
  output seqCtl_t ctl,
  output logic    running,
  output logic    dbgSt,
  output logic    trapSt,
  output logic    irq,
  output logic    loExec
);
  logic [1:0] endCnt, brCnt, endN;
  logic       pend;
  logic       issue, brReq, dbgHit, trapHit, stopNow;
  logic       armNew, pendSet, resolve;

  always_comb begin
    issue   = running & ~start;
    loExec  = issue & ~immFlag;
    brReq   = loExec & brTaken;
    dbgHit  = issue & dbgFlag & brkEn;
    trapHit = issue & trapFlag & trapEn;
    endN    = endCnt;
    if (issue && endFlag)    endN = 2'd2;
    if (dbgHit || trapHit)   endN = 2'd1;
    stopNow = issue & (endN == 2'd1);
    armNew  = brReq & (brCnt == 2'd0);
    pendSet = brReq & (brCnt != 2'd0);
    resolve = issue & (brCnt == 2'd1);
    ctl.loadStart   = start;
    ctl.takeBr      = resolve;
    ctl.incPc       = issue & ~resolve;
    ctl.armTgt      = armNew;
    ctl.savePend    = pendSet & ~resolve;
    ctl.promoteIn   = resolve & pendSet;
    ctl.promotePend = resolve & pend & ~pendSet;
    ctl.loadImm     = issue & immFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      endCnt  <= '0;
      brCnt   <= '0;
      pend    <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      endCnt  <= '0;
      brCnt   <= '0;
      pend    <= 1'b0;
    end else if (issue) begin
      if (stopNow) begin
        running <= 1'b0;
        endCnt  <= '0;
        brCnt   <= '0;
        pend    <= 1'b0;
      end else begin
        endCnt <= (endN == 2'd2) ? 2'd1 : 2'd0;
        if (resolve) begin
          brCnt <= (pend || pendSet) ? 2'd2 : 2'd0;
          pend  <= 1'b0;
        end else begin
          if (brCnt == 2'd2)  brCnt <= 2'd1;
          else if (armNew)    brCnt <= 2'd1;
          if (pendSet)        pend  <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbgSt  <= 1'b0;
      trapSt <= 1'b0;
      irq    <= 1'b0;
    end else begin
      dbgSt  <= dbgHit  | (dbgSt  & ~dbgClr);
      trapSt <= trapHit | (trapSt & ~trapClr);
      irq    <= dbgHit | trapHit;
    end
  end
endmodule

// File: rtl/vseq_dp.sv
module vseq_dp
  import vseq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] startPc,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic [31:0]       loWord,
  output logic [ADDR_W-1:0] pc,
  output logic [31:0]       immReg
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(8);
  logic [ADDR_W-1:0] brTgt, pendTgt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      brTgt   <= '0;
      pendTgt <= '0;
      immReg  <= '0;
    end else begin
      if (ctl.loadStart)    pc <= {startPc[ADDR_W-1:3], 3'b000};
      else if (ctl.takeBr)  pc <= brTgt;
      else if (ctl.incPc)   pc <= pc + STEP;
      if (ctl.armTgt || ctl.promoteIn) brTgt <= brTarget;
      else if (ctl.promotePend)        brTgt <= pendTgt;
      if (ctl.savePend)     pendTgt <= brTarget;
      if (ctl.loadImm)      immReg  <= loWord;
    end
  end
endmodule

// File: rtl/vseq_top.sv
module vseq_top
  import vseq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startPc,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [63:0]       memData,
  input  logic              brTaken,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic              brkEn,
  input  logic              trapEn,
  input  logic              dbgClr,
  input  logic              trapClr,
  output logic              upStrobe,
  output logic [5:0]        upOp,
  output logic              loStrobe,
  output logic [6:0]        loOp,
  output logic [31:0]       immReg,
  output logic [2:0]        status,
  output logic              irq
);
  seqCtl_t ctl;
  logic running, dbgSt, trapSt, loExec;

  vseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .immFlag(memData[63]), .endFlag(memData[62]),
    .dbgFlag(memData[60]), .trapFlag(memData[59]),
    .brTaken(brTaken), .brkEn(brkEn), .trapEn(trapEn),
    .dbgClr(dbgClr), .trapClr(trapClr),
    .ctl(ctl), .running(running), .dbgSt(dbgSt), .trapSt(trapSt),
    .irq(irq), .loExec(loExec)
  );

  vseq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startPc(startPc),
    .brTarget(brTarget), .loWord(memData[31:0]),
    .pc(memAddr), .immReg(immReg)
  );

  assign upStrobe = running & ~start;
  assign loStrobe = loExec;
  assign upOp     = memData[37:32];
  assign loOp     = memData[31:25];
  assign status   = {trapSt, dbgSt, running};
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] memAddr,
  input logic [63:0]       memData,
  input logic              brkEn,
  input logic              trapEn,
  input logic              dbgClr,
  input logic              upStrobe,
  input logic              loStrobe,
  input logic [2:0]        status,
  input logic              irq
);
  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  a_r9_irq_from_run: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(status[0]));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!status[0] && !start) |=> $stable(memAddr));
  a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !status[0] |-> (!upStrobe && !loStrobe));
  a_r3_imm_no_lower: assert property (@(posedge clk) disable iff (!rstN)
    (status[0] && memData[63]) |-> !loStrobe);
  a_r7_dbg_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (status[1] && !dbgClr) |=> status[1]);
  a_r4_end_one_more: assert property (@(posedge clk) disable iff (!rstN)
    (status[0] && !start && memData[62] && !(memData[60] && brkEn)
     && !(memData[59] && trapEn)) |=> status[0]);
endmodule

bind vseq_top vseq_checker #(.ADDR_W(ADDR_W)) u_vseq_checker (
  .clk(clk), .rstN(rstN), .start(start), .memAddr(memAddr),
  .memData(memData), .brkEn(brkEn), .trapEn(trapEn), .dbgClr(dbgClr),
  .upStrobe(upStrobe), .loStrobe(loStrobe), .status(status), .irq(irq)
);

// File: tb/vseq_top_bench.sv
`timescale 1ns/1ps
module vseq_top_bench;
  localparam int ADDR_W = 8;
  localparam int WORDS = 2 ** (ADDR_W - 3);

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [ADDR_W-1:0] startPc = '0, memAddr, brTarget;
  logic [63:0] memData;
  logic brTaken, brkEn = 1'b0, trapEn = 1'b0, dbgClr = 1'b0, trapClr = 1'b0;
  logic upStrobe, loStrobe, irq;
  logic [5:0] upOp;
  logic [6:0] loOp;
  logic [31:0] immReg;
  logic [2:0] status;

  logic [63:0] mem [WORDS];
  int checks = 0, fails = 0, irqCnt = 0;
  int expA [16];
  int gotA [32];
  int gotN;
  logic gotLoS [32];
  logic [5:0] gotUp0;
  logic [6:0] gotLo0;

  always #10 clk = ~clk;

  assign memData  = mem[memAddr[ADDR_W-1:3]];
  assign brTaken  = memData[24];
  assign brTarget = memData[ADDR_W-1:0];

  vseq_top #(.ADDR_W(ADDR_W)) u_vseq_top (
    .clk(clk), .rstN(rstN), .start(start), .startPc(startPc),
    .memAddr(memAddr), .memData(memData), .brTaken(brTaken),
    .brTarget(brTarget), .brkEn(brkEn), .trapEn(trapEn),
    .dbgClr(dbgClr), .trapClr(trapClr), .upStrobe(upStrobe),
    .upOp(upOp), .loStrobe(loStrobe), .loOp(loOp), .immReg(immReg),
    .status(status), .irq(irq)
  );

  always @(negedge clk) if (irq) irqCnt++;

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < WORDS; i++) mem[i] = 64'h0;
  endtask

  function automatic logic [63:0] word(input logic i, e, d, t,
                                       input logic [31:0] lo);
    return {i, e, 1'b0, d, t, 27'h0, lo};
  endfunction

  task automatic runTrace(input logic [ADDR_W-1:0] sp);
    @(negedge clk); startPc = sp; start = 1'b1;
    @(negedge clk); start = 1'b0;
    gotN = 0;
    while (status[0] && gotN < 30) begin
      if (gotN == 0) begin gotUp0 = upOp; gotLo0 = loOp; end
      gotA[gotN] = int'(memAddr);
      gotLoS[gotN] = loStrobe;
      gotN++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic cmpTrace(input string req, input int n);
    check(req, gotN, n);
    for (int i = 0; i < n; i++) check(req, gotA[i], expA[i]);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    check("R10 reset status", status, 0);
    check("R10 reset strobe", upStrobe, 0);
    check("R9 reset irq", irq, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R4: straight line with end flag on word 2
    clearMem();
    mem[0] = {1'b0, 25'h0, 6'h2A, 7'h55, 25'h0};
    mem[2] = word(0, 1, 0, 0, 0);
    runTrace(8'h00);
    expA[0] = 0; expA[1] = 8; expA[2] = 16; expA[3] = 24;
    cmpTrace("R4 end one more", 4);
    check("R2 upOp", gotUp0, 6'h2A);
    check("R2 loOp", gotLo0, 7'h55);
    check("R4 run cleared", status[0], 0);

    // R1: unaligned start address is aligned
    runTrace(8'h0B);
    expA[0] = 8; expA[1] = 16; expA[2] = 24;
    cmpTrace("R1 start aligned", 3);

    // R10: stopped unit holds the address and issues nothing
    for (int i = 0; i < 4; i++) begin
      check("R10 idle addr", memAddr, 8'h20);
      check("R10 idle strobe", upStrobe | loStrobe, 0);
      @(negedge clk);
    end

    // R5: single branch with one delay slot
    clearMem();
    mem[0] = word(0, 0, 0, 0, 32'h0100_0040);
    mem[8] = word(0, 1, 0, 0, 0);
    runTrace(8'h00);
    expA[0] = 0; expA[1] = 8; expA[2] = 64; expA[3] = 72;
    cmpTrace("R5 delay slot", 4);

    // R6: branch in the delay slot is queued and re-armed
    clearMem();
    mem[0]  = word(0, 0, 0, 0, 32'h0100_0040);
    mem[1]  = word(0, 0, 0, 0, 32'h0100_0080);
    mem[16] = word(0, 1, 0, 0, 0);
    runTrace(8'h00);
    expA[0] = 0; expA[1] = 8; expA[2] = 64; expA[3] = 72;
    expA[4] = 128; expA[5] = 136;
    cmpTrace("R6 queued branch", 6);

    // R3: immediate word loads immReg and suppresses its branch
    clearMem();
    mem[0] = word(1, 0, 0, 0, 32'h0100_0040);
    mem[1] = word(0, 1, 0, 0, 32'h0000_0000);
    runTrace(8'h00);
    expA[0] = 0; expA[1] = 8; expA[2] = 16;
    cmpTrace("R3 branch ignored", 3);
    check("R3 immReg", immReg, 32'h0100_0040);
    check("R3 loStrobe low", gotLoS[0], 0);
    check("R3 loStrobe next", gotLoS[1], 1);

    // R7: debug flag disabled has no effect
    clearMem();
    mem[0] = word(0, 1, 1, 0, 0);
    irqCnt = 0;
    runTrace(8'h00);
    expA[0] = 0; expA[1] = 8;
    cmpTrace("R7 disabled", 2);
    check("R7 disabled status", status[1], 0);
    check("R7 disabled irq", irqCnt, 0);

    // R7 R9: debug flag enabled halts after the flagged word
    clearMem();
    mem[1] = word(0, 0, 1, 0, 0);
    brkEn = 1'b1; irqCnt = 0;
    runTrace(8'h00);
    expA[0] = 0; expA[1] = 8;
    cmpTrace("R7 halt", 2);
    check("R7 sticky", status[1], 1);
    check("R9 irq single pulse", irqCnt, 1);
    repeat (3) @(negedge clk);
    check("R9 still sticky", status[1], 1);
    dbgClr = 1'b1; @(negedge clk); dbgClr = 1'b0;
    check("R9 dbg cleared", status[1], 0);
    brkEn = 1'b0;

    // R8: trap disabled then enabled
    clearMem();
    mem[0] = word(0, 0, 0, 1, 0);
    mem[2] = word(0, 1, 0, 0, 0);
    irqCnt = 0;
    runTrace(8'h00);
    expA[0] = 0; expA[1] = 8; expA[2] = 16; expA[3] = 24;
    cmpTrace("R8 disabled", 4);
    check("R8 disabled status", status[2], 0);
    trapEn = 1'b1; irqCnt = 0;
    runTrace(8'h00);
    expA[0] = 0;
    cmpTrace("R8 halt", 1);
    check("R8 sticky", status[2], 1);
    check("R8 irq", irqCnt, 1);
    trapClr = 1'b1; @(negedge clk); trapClr = 1'b0;
    check("R9 trap cleared", status[2], 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule